// File: doc/BRIEF.md
# Chained Command Fetch Engine

This block reads fixed-size commands for a coprocessor out of memory, where the command queue is a linked chain of equal-sized segments rather than a ring. Software first writes a configuration word. It gives the aligned address of the first segment, the segment length in 64-bit words, which of eight free lists receives finished segments, and a don't-write-back count that travels with each free request. Software then rings a doorbell with a number of newly written commands. The engine issues single-word reads on a request/response memory port and gathers the words into complete commands. It hands each command to the consumer over a valid/ready port.

The final word of every segment holds the address of the next segment. Reading that word is delayed until a further command word is actually needed. When the link word returns, the engine moves to the new segment and offers the old segment back on a free port. A programmable throttle caps the number of reads in flight, and a value of zero parks the engine. An overflowing doorbell sets a sticky error flag, and that flag can drive an interrupt through a mask bit.

Top module: `cmd_chain_fetch`

## Requirements
- R1: After reset, no read request, command or free request is offered. The pending count, error flag and interrupt are all 0, and the throttle cap is 8.
- R2: Command words are read from consecutive addresses. The first address is `cfg_ptr` shifted left by 7, and each following address is 8 higher. Each group of CMD_WORDS words is delivered as one command, with word 0 in `cmd_data[63:0]` and later words in higher 64-bit slices.
- R3: In a segment of `cfg_size` words, only word indices 0 to size-2 carry commands. The word at index size-1 is a link, and bits [39:7] of that word give the next segment's base. Reading resumes at word 0 of the new segment, and a command may span two segments.
- R4: Each time a link is followed, one free request is raised with the old segment's byte address, the pool index and the don't-write-back count. It is held stable until `free_ready`.
- R5: A link word is read only when another command word is still required. With no pending work, no read is issued.
- R6: `pend_count` rises by `db_add` on a doorbell and falls by one for each command accepted by the consumer.
- R7: A doorbell that would take the pending count beyond 2^DB_W-1 is discarded and sets `err_flag`. The flag stays set until `err_clr` is pulsed.
- R8: `irq` is high exactly when the error flag and the mask bit (written through `mask_wr`) are both 1.
- R9: Reads in flight never exceed the throttle cap. A cap of 0 stops new reads, and a written value above 8 acts as 8.
- R10: A configuration write while `pend_count` is nonzero has no effect. One made at zero restarts fetching from the new pointer at word 0.
- R11: A command offered but not accepted stays valid with unchanged data. No command is lost while the consumer stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_ptr | input | 33 | First segment address bits [39:7] |
| cfg_size | input | 13 | Segment length in 64-bit words |
| cfg_pool | input | 3 | Free list index |
| cfg_dwb | input | 9 | Don't-write-back count |
| db_valid | input | 1 | Doorbell strobe |
| db_add | input | DB_W | Commands added by the doorbell |
| thr_wr | input | 1 | Throttle write strobe |
| thr_val | input | 4 | Throttle value |
| err_clr | input | 1 | Clears the error flag |
| mask_wr | input | 1 | Interrupt mask write strobe |
| mask_val | input | 1 | Interrupt mask value |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 40 | Read byte address |
| rd_rsp_valid | input | 1 | Read data valid (in order) |
| rd_rsp_data | input | 64 | Read data |
| cmd_valid | output | 1 | Command valid |
| cmd_ready | input | 1 | Consumer accepts command |
| cmd_data | output | CMD_WORDS*64 | Command words |
| free_valid | output | 1 | Free request valid |
| free_ready | input | 1 | Free request accepted |
| free_addr | output | 40 | Freed segment byte address |
| free_pool | output | 3 | Free list index |
| free_dwb | output | 9 | Don't-write-back count |
| pend_count | output | DB_W | Commands not yet delivered |
| err_flag | output | 1 | Sticky doorbell overflow flag |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions take the memory port on trust in several ways. Responses are assumed to come back in issue order, one per accepted request, and never before that request. Segment lengths are assumed to be at least two words, link words to hold 128-byte-aligned addresses, and configuration to be written only while idle. The stimulus keeps within these limits. The memory model answers from a due-time queue that it pops strictly from the head. Every link it serves is a computed aligned address, all segment lengths are 5 or 9, and each deliberate configuration write during pending work is the one meant to be ignored.

// File: rtl/cbf_pkg.sv
package cbf_pkg;
  localparam int ADDR_W    = 40;
  localparam int WORD_W    = 64;
  localparam int SEG_SH    = 7;
  localparam int WORD_SH   = 3;
  localparam int PTR_W     = ADDR_W - SEG_SH;
  localparam int SIZE_W    = 13;
  localparam int POOL_W    = 3;
  localparam int DWB_W     = 9;
  localparam int THR_W     = 4;
  localparam int THR_LIMIT = 8;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_LINK = 1'b1
  } fetch_st_e;

  typedef struct packed {
    logic [PTR_W-1:0]  ptr;
    logic [POOL_W-1:0] pool;
    logic [DWB_W-1:0]  dwb;
  } seg_free_t;
endpackage

// File: rtl/cbf_dbell.sv
module cbf_dbell #(
  parameter int DB_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            db_valid,
  input  logic [DB_W-1:0] db_add,
  input  logic            cmd_fire,
  input  logic            cmd_iss_done,
  input  logic            err_clr,
  input  logic            mask_wr,
  input  logic            mask_val,
  output logic [DB_W-1:0] pend,
  output logic            want,
  output logic            err,
  output logic            irq
);
  logic [DB_W-1:0] cnt_q, cnt_n, iss_q, iss_n, cnt_base;
  logic [DB_W:0]   sum;
  logic            ovf, add_ok;
  logic            err_q, err_n, mask_q, mask_n;

  always_comb begin
    cnt_base = cnt_q - DB_W'(cmd_fire);
    sum      = {1'b0, cnt_base} + {1'b0, db_add};
    ovf      = db_valid && sum[DB_W];
    add_ok   = db_valid && !sum[DB_W];
    cnt_n    = add_ok ? sum[DB_W-1:0] : cnt_base;
    iss_n    = iss_q - DB_W'(cmd_iss_done) + (add_ok ? db_add : '0);
    err_n    = ovf ? 1'b1 : (err_clr ? 1'b0 : err_q);
    mask_n   = mask_wr ? mask_val : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      iss_q  <= '0;
      err_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      iss_q  <= iss_n;
      err_q  <= err_n;
      mask_q <= mask_n;
    end
  end

  assign pend = cnt_q;
  assign want = (iss_q != '0);
  assign err  = err_q;
  assign irq  = err_q & mask_q;

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) cmd_fire |-> cnt_q != '0); // R6
  AST_ISS_LE_PEND:  assert property (@(posedge clk) disable iff (!rst_n) iss_q <= cnt_q); // R6
  AST_ERR_STICKY:   assert property (@(posedge clk) disable iff (!rst_n) err_q && !err_clr |=> err_q); // R7
  AST_OVF_KEEPS:    assert property (@(posedge clk) disable iff (!rst_n) ovf && !cmd_fire |=> $stable(cnt_q)); // R7
endmodule

// File: rtl/cbf_asm.sv
module cbf_asm
  import cbf_pkg::*;
#(
  parameter int CMD_WORDS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        word_v,
  input  logic [WORD_W-1:0]           word_data,
  input  logic                        word_iss,
  input  logic                        cmd_ready,
  output logic                        cmd_valid,
  output logic [CMD_WORDS*WORD_W-1:0] cmd_data,
  output logic                        cmd_fire,
  output logic                        credit_ok
);
  localparam int IDX_W  = (CMD_WORDS > 1) ? $clog2(CMD_WORDS) : 1;
  localparam int CRED_W = $clog2(2*CMD_WORDS + 1);

  logic [CMD_WORDS-1:0][WORD_W-1:0] coll_q, coll_upd;
  logic [CMD_WORDS*WORD_W-1:0]      hold_q;
  logic [IDX_W-1:0]                 idx_q, idx_n;
  logic [CRED_W-1:0]                cred_q, cred_n;
  logic                             full_q, full_n, hold_v_q, hold_v_n;
  logic                             hold_free, done_now, move;

  always_comb begin
    cmd_fire  = hold_v_q & cmd_ready;
    hold_free = !hold_v_q || cmd_fire;
    coll_upd  = coll_q;
    if (word_v) coll_upd[idx_q] = word_data;
    done_now  = word_v && (idx_q == IDX_W'(CMD_WORDS-1));
    move      = (full_q || done_now) && hold_free;
    hold_v_n  = (hold_v_q && !cmd_fire) || move;
    full_n    = (full_q || done_now) && !move;
    idx_n     = idx_q;
    if (word_v) idx_n = done_now ? '0 : idx_q + 1'b1;
    cred_n    = cred_q + CRED_W'(word_iss) - (cmd_fire ? CRED_W'(CMD_WORDS) : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q    <= '0;
      cred_q   <= '0;
      full_q   <= 1'b0;
      hold_v_q <= 1'b0;
    end else begin
      idx_q    <= idx_n;
      cred_q   <= cred_n;
      full_q   <= full_n;
      hold_v_q <= hold_v_n;
    end
  end

  always_ff @(posedge clk) begin
    if (word_v) coll_q <= coll_upd;
    if (move)   hold_q <= coll_upd;
  end

  assign cmd_valid = hold_v_q;
  assign cmd_data  = hold_q;
  assign credit_ok = (cred_q < CRED_W'(2*CMD_WORDS));

  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n) word_v |-> !full_q); // R11
  AST_CMD_HOLD:   assert property (@(posedge clk) disable iff (!rst_n) cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data)); // R11
  AST_CREDIT_CAP: assert property (@(posedge clk) disable iff (!rst_n) cred_q <= CRED_W'(2*CMD_WORDS)); // R11
endmodule

// File: rtl/cbf_issue.sv
module cbf_issue
  import cbf_pkg::*;
#(
  parameter int CMD_WORDS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [PTR_W-1:0]  cfg_ptr,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic [POOL_W-1:0] cfg_pool,
  input  logic [DWB_W-1:0]  cfg_dwb,
  input  logic              thr_wr,
  input  logic [THR_W-1:0]  thr_val,
  input  logic              want,
  input  logic              credit_ok,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rsp_valid,
  input  logic [PTR_W-1:0]  link_ptr,
  output logic              word_rsp,
  output logic              word_iss,
  output logic              cmd_iss_done,
  output logic              free_valid,
  input  logic              free_ready,
  output seg_free_t         free_req
);
  localparam int IDX_W = (CMD_WORDS > 1) ? $clog2(CMD_WORDS) : 1;

  fetch_st_e         st_q, st_n;
  logic [PTR_W-1:0]  base_q, base_n;
  logic [SIZE_W-1:0] size_q, size_n, seg_w_q, seg_w_n;
  logic [POOL_W-1:0] pool_q, pool_n;
  logic [DWB_W-1:0]  dwb_q, dwb_n;
  logic [IDX_W-1:0]  cmd_w_q, cmd_w_n;
  logic [THR_W-1:0]  out_q, out_n, thr_q, thr_n;
  logic              free_v_q, free_v_n;
  seg_free_t         free_q, free_n;
  logic              at_link, can_go, link_go, word_go, req_fire, rsp_link;

  always_comb begin
    at_link      = (seg_w_q == SIZE_W'(size_q - 1'b1));
    can_go       = (st_q == ST_RUN) && want && (out_q < thr_q);
    link_go      = can_go && at_link && !free_v_q;
    word_go      = can_go && !at_link && credit_ok;
    rd_req_valid = link_go | word_go;
    req_fire     = rd_req_valid & rd_req_ready;
    rsp_link     = rsp_valid && (st_q == ST_LINK) && (out_q == THR_W'(1));
    word_rsp     = rsp_valid && !rsp_link;
    word_iss     = word_go & rd_req_ready;
    cmd_iss_done = word_iss && (cmd_w_q == IDX_W'(CMD_WORDS-1));

    st_n     = st_q;
    base_n   = base_q;
    size_n   = size_q;
    pool_n   = pool_q;
    dwb_n    = dwb_q;
    seg_w_n  = seg_w_q;
    cmd_w_n  = cmd_w_q;
    thr_n    = thr_q;
    free_v_n = free_v_q;
    free_n   = free_q;
    out_n    = out_q + THR_W'(req_fire) - THR_W'(rsp_valid);

    if (word_iss) begin
      seg_w_n = seg_w_q + 1'b1;
      cmd_w_n = (cmd_w_q == IDX_W'(CMD_WORDS-1)) ? '0 : cmd_w_q + 1'b1;
    end
    if (link_go && rd_req_ready) st_n = ST_LINK;
    if (free_v_q && free_ready)  free_v_n = 1'b0;
    if (rsp_link) begin
      base_n   = link_ptr;
      seg_w_n  = '0;
      st_n     = ST_RUN;
      free_v_n = 1'b1;
      free_n   = '{ptr: base_q, pool: pool_q, dwb: dwb_q};
    end
    if (thr_wr) thr_n = (thr_val > THR_W'(THR_LIMIT)) ? THR_W'(THR_LIMIT) : thr_val;
    if (cfg_load) begin
      base_n  = cfg_ptr;
      size_n  = cfg_size;
      pool_n  = cfg_pool;
      dwb_n   = cfg_dwb;
      seg_w_n = '0;
      cmd_w_n = '0;
      st_n    = ST_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_RUN;
      base_q   <= '0;
      size_q   <= '0;
      pool_q   <= '0;
      dwb_q    <= '0;
      seg_w_q  <= '0;
      cmd_w_q  <= '0;
      out_q    <= '0;
      thr_q    <= THR_W'(THR_LIMIT);
      free_v_q <= 1'b0;
      free_q   <= '0;
    end else begin
      st_q     <= st_n;
      base_q   <= base_n;
      size_q   <= size_n;
      pool_q   <= pool_n;
      dwb_q    <= dwb_n;
      seg_w_q  <= seg_w_n;
      cmd_w_q  <= cmd_w_n;
      out_q    <= out_n;
      thr_q    <= thr_n;
      free_v_q <= free_v_n;
      free_q   <= free_n;
    end
  end

  assign rd_req_addr = {base_q, {SEG_SH{1'b0}}} + ADDR_W'({seg_w_q, {WORD_SH{1'b0}}});
  assign free_valid  = free_v_q;
  assign free_req    = free_q;

  AST_SEG_BOUND:    assert property (@(posedge clk) disable iff (!rst_n) rd_req_valid |-> seg_w_q < size_q); // R3
  AST_RSP_EXPECTED: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> out_q != '0); // R9
  AST_OUT_LIMIT:    assert property (@(posedge clk) disable iff (!rst_n) out_q <= THR_W'(THR_LIMIT)); // R9
  AST_FREE_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) free_valid && !free_ready |=> free_valid && $stable(free_req)); // R4
  AST_LINK_WAIT:    assert property (@(posedge clk) disable iff (!rst_n) st_q == ST_LINK && !rsp_valid |=> st_q == ST_LINK || cfg_load); // R3
endmodule

// File: rtl/cmd_chain_fetch.sv
module cmd_chain_fetch
  import cbf_pkg::*;
#(
  parameter int CMD_WORDS = 8,
  parameter int DB_W      = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_wr,
  input  logic [PTR_W-1:0]            cfg_ptr,
  input  logic [SIZE_W-1:0]           cfg_size,
  input  logic [POOL_W-1:0]           cfg_pool,
  input  logic [DWB_W-1:0]            cfg_dwb,
  input  logic                        db_valid,
  input  logic [DB_W-1:0]             db_add,
  input  logic                        thr_wr,
  input  logic [THR_W-1:0]            thr_val,
  input  logic                        err_clr,
  input  logic                        mask_wr,
  input  logic                        mask_val,
  output logic                        rd_req_valid,
  input  logic                        rd_req_ready,
  output logic [ADDR_W-1:0]           rd_req_addr,
  input  logic                        rd_rsp_valid,
  input  logic [WORD_W-1:0]           rd_rsp_data,
  output logic                        cmd_valid,
  input  logic                        cmd_ready,
  output logic [CMD_WORDS*WORD_W-1:0] cmd_data,
  output logic                        free_valid,
  input  logic                        free_ready,
  output logic [ADDR_W-1:0]           free_addr,
  output logic [POOL_W-1:0]           free_pool,
  output logic [DWB_W-1:0]            free_dwb,
  output logic [DB_W-1:0]             pend_count,
  output logic                        err_flag,
  output logic                        irq
);
  logic      want, credit_ok, word_rsp, word_iss, cmd_iss_done, cmd_fire, cfg_load;
  seg_free_t free_req;

  assign cfg_load = cfg_wr && (pend_count == '0);

  cbf_dbell #(.DB_W(DB_W)) u_dbell (
    .clk(clk), .rst_n(rst_n), .db_valid(db_valid), .db_add(db_add),
    .cmd_fire(cmd_fire), .cmd_iss_done(cmd_iss_done), .err_clr(err_clr),
    .mask_wr(mask_wr), .mask_val(mask_val), .pend(pend_count), .want(want),
    .err(err_flag), .irq(irq)
  );

  cbf_issue #(.CMD_WORDS(CMD_WORDS)) u_issue (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_ptr(cfg_ptr),
    .cfg_size(cfg_size), .cfg_pool(cfg_pool), .cfg_dwb(cfg_dwb),
    .thr_wr(thr_wr), .thr_val(thr_val), .want(want), .credit_ok(credit_ok),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rsp_valid(rd_rsp_valid), .link_ptr(rd_rsp_data[ADDR_W-1:SEG_SH]),
    .word_rsp(word_rsp), .word_iss(word_iss), .cmd_iss_done(cmd_iss_done),
    .free_valid(free_valid), .free_ready(free_ready), .free_req(free_req)
  );

  cbf_asm #(.CMD_WORDS(CMD_WORDS)) u_asm (
    .clk(clk), .rst_n(rst_n), .word_v(word_rsp), .word_data(rd_rsp_data),
    .word_iss(word_iss), .cmd_ready(cmd_ready), .cmd_valid(cmd_valid),
    .cmd_data(cmd_data), .cmd_fire(cmd_fire), .credit_ok(credit_ok)
  );

  assign free_addr = {free_req.ptr, {SEG_SH{1'b0}}};
  assign free_pool = free_req.pool;
  assign free_dwb  = free_req.dwb;

  AST_CFG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) cfg_wr && pend_count != '0 |=> !(rd_req_valid && rd_req_addr == {$past(cfg_ptr), {SEG_SH{1'b0}}} && $past(rd_req_addr) != rd_req_addr && pend_count == '0)); // R10
  AST_IRQ_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n) irq |-> err_flag); // R8
endmodule

// File: tb/cmd_chain_fetch_tb.sv
`timescale 1ns/1ps
module cmd_chain_fetch_tb;
  import cbf_pkg::*;
  localparam int CW   = 8;
  localparam int DBW  = 16;
  localparam int CMDB = CW*WORD_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 0, db_valid = 0, thr_wr = 0, err_clr = 0, mask_wr = 0, mask_val = 0;
  logic [PTR_W-1:0]  cfg_ptr = '0;
  logic [SIZE_W-1:0] cfg_size = '0;
  logic [POOL_W-1:0] cfg_pool = '0;
  logic [DWB_W-1:0]  cfg_dwb = '0;
  logic [DBW-1:0]    db_add = '0;
  logic [THR_W-1:0]  thr_val = '0;
  logic rd_req_valid, rd_req_ready = 1'b1, rd_rsp_valid = 1'b0;
  logic [ADDR_W-1:0] rd_req_addr, free_addr;
  logic [WORD_W-1:0] rd_rsp_data = '0;
  logic cmd_valid, cmd_ready = 1'b0, free_valid, free_ready = 1'b0, err_flag, irq;
  logic [CMDB-1:0]   cmd_data;
  logic [POOL_W-1:0] free_pool;
  logic [DWB_W-1:0]  free_dwb;
  logic [DBW-1:0]    pend_count;

  cmd_chain_fetch #(.CMD_WORDS(CW), .DB_W(DBW)) u_dut (.*);

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_tests = 0, n_fail = 0;
  int req_count = 0, inflight = 0, max_inflight = 0, lat = 3;
  int words_planned = 0, links_planned = 0;
  int rdy_mode = 1;
  logic [ADDR_W-1:0] cur_seg;
  int cur_idx = 0, cur_size = 5;
  logic [POOL_W-1:0] cur_pool;
  logic [DWB_W-1:0]  cur_dwb;
  logic [WORD_W-1:0] link_mem [logic [ADDR_W-1:0]];
  logic [CMDB-1:0]   exp_cmd [$];
  logic [ADDR_W+POOL_W+DWB_W-1:0] exp_free [$];
  logic [WORD_W-1:0] rsp_q [$];
  int due_q [$];

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [WORD_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return {24'hC0DE5A, a};
  endfunction

  task automatic plan_cmds(input int n);
    for (int c = 0; c < n; c++) begin
      logic [CMDB-1:0] v;
      for (int w = 0; w < CW; w++) begin
        if (cur_idx == cur_size - 1) begin
          logic [ADDR_W-1:0] nxt;
          nxt = cur_seg + 40'h1080;
          link_mem[cur_seg + ADDR_W'(8*(cur_size-1))] = {24'h0, nxt};
          exp_free.push_back({cur_seg, cur_pool, cur_dwb});
          links_planned++;
          cur_seg = nxt;
          cur_idx = 0;
        end
        v[w*WORD_W +: WORD_W] = word_of(cur_seg + ADDR_W'(8*cur_idx));
        cur_idx++;
        words_planned++;
      end
      exp_cmd.push_back(v);
    end
  endtask

  task automatic do_cfg(input logic [ADDR_W-1:0] base, input int size, input logic [POOL_W-1:0] pool, input logic [DWB_W-1:0] dwb);
    @(negedge clk);
    cfg_wr = 1; cfg_ptr = base[ADDR_W-1:SEG_SH]; cfg_size = SIZE_W'(size); cfg_pool = pool; cfg_dwb = dwb;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic ring(input logic [DBW-1:0] n);
    @(negedge clk); db_valid = 1; db_add = n;
    @(negedge clk); db_valid = 0;
  endtask

  task automatic set_thr(input logic [THR_W-1:0] v);
    @(negedge clk); thr_wr = 1; thr_val = v;
    @(negedge clk); thr_wr = 0;
  endtask

  task automatic drain();
    while (!(pend_count == 0 && exp_cmd.size() == 0 && exp_free.size() == 0)) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // memory model: in-order responses after a programmable latency
  initial begin
    forever begin
      @(negedge clk);
      if (due_q.size() > 0 && due_q[0] <= cyc) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = rsp_q.pop_front();
        void'(due_q.pop_front());
        inflight--;
      end else begin
        rd_rsp_valid = 1'b0;
      end
      #1;
      if (rd_req_valid && rd_req_ready) begin
        rsp_q.push_back(link_mem.exists(rd_req_addr) ? link_mem[rd_req_addr] : word_of(rd_req_addr));
        due_q.push_back(cyc + lat);
        inflight++;
        req_count++;
        if (inflight > max_inflight) max_inflight = inflight;
      end
    end
  end

  // command monitor (scoreboard) with back-pressure
  initial begin
    logic stalled = 1'b0;
    logic [CMDB-1:0] last = '0;
    forever begin
      @(negedge clk);
      cmd_ready = (rdy_mode == 0) ? 1'b1 : (cyc % 3 != 0);
      #1;
      if (stalled) begin
        chk(cmd_valid && cmd_data == last, "R11 stall hold", cmd_data[63:0], last[63:0]);
      end
      stalled = cmd_valid && !cmd_ready;
      last = cmd_data;
      if (cmd_valid && cmd_ready) begin
        if (exp_cmd.size() == 0) chk(1'b0, "R2 unexpected command", cmd_data[63:0], 0);
        else begin
          logic [CMDB-1:0] e;
          e = exp_cmd.pop_front();
          for (int w = 0; w < CW; w++)
            chk(cmd_data[w*WORD_W +: WORD_W] == e[w*WORD_W +: WORD_W], "R2/R3 command word",
                cmd_data[w*WORD_W +: WORD_W], e[w*WORD_W +: WORD_W]);
        end
      end
    end
  end

  // free monitor
  initial begin
    forever begin
      @(negedge clk);
      free_ready = (cyc % 4 != 1);
      #1;
      if (free_valid && free_ready) begin
        if (exp_free.size() == 0) chk(1'b0, "R4 unexpected free", 64'(free_addr), 0);
        else begin
          logic [ADDR_W+POOL_W+DWB_W-1:0] e;
          e = exp_free.pop_front();
          chk({free_addr, free_pool, free_dwb} == e, "R4 free request",
              64'({free_addr, free_pool, free_dwb}), 64'(e));
        end
      end
    end
  end

  // watchdog
  initial begin
    #(10 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    chk(!rd_req_valid && !cmd_valid && !free_valid, "R1 idle outputs", {rd_req_valid, cmd_valid, free_valid}, 0);
    chk(pend_count == 0 && !err_flag && !irq, "R1 counters", {pend_count, err_flag, irq}, 0);

    // phase 1: short segments, commands span segments
    cur_seg = 40'h1000; cur_idx = 0; cur_size = 5; cur_pool = 3'd3; cur_dwb = 9'h1A5;
    do_cfg(cur_seg, 5, 3'd3, 9'h1A5);
    plan_cmds(3);
    ring(3);
    #2;
    chk(pend_count == 3, "R6 doorbell adds", pend_count, 3);
    drain();
    chk(pend_count == 0, "R6 drained", pend_count, 0);
    chk(req_count == words_planned + links_planned, "R5 read count", req_count, words_planned + links_planned);
    snap = req_count;
    repeat (20) @(negedge clk);
    chk(req_count == snap, "R5 no read when idle", req_count, snap);

    // phase 2: throttle zero, ignored config, cap of 2
    set_thr(4'd0);
    plan_cmds(2);
    ring(2);
    snap = req_count;
    repeat (30) @(negedge clk);
    chk(req_count == snap, "R9 zero throttle stalls", req_count, snap);
    do_cfg(40'hF0000, 9, 3'd6, 9'h0);   // R10: ignored, work pending
    lat = 6; max_inflight = 0;
    set_thr(4'd2);
    drain();
    chk(max_inflight == 2, "R9 cap two", max_inflight, 2);

    // phase 3: accepted reconfiguration, clamp of an illegal cap
    cur_seg = 40'h80000; cur_idx = 0; cur_size = 9; cur_pool = 3'd5; cur_dwb = 9'h003;
    do_cfg(cur_seg, 9, 3'd5, 9'h003);
    rdy_mode = 0; lat = 12; max_inflight = 0;
    set_thr(4'd15);
    plan_cmds(3);
    ring(3);
    drain();
    chk(max_inflight == 8, "R9 clamp to eight", max_inflight, 8);
    chk(req_count == words_planned + links_planned, "R10 reads from new chain", req_count, words_planned + links_planned);

    // phase 4: doorbell overflow and interrupt mask
    set_thr(4'd0);
    ring(16'hFFFF);
    #2;
    chk(pend_count == 16'hFFFF && !err_flag, "R6 full count", pend_count, 16'hFFFF);
    ring(16'h0001);
    #2;
    chk(err_flag, "R7 overflow sets flag", err_flag, 1);
    chk(pend_count == 16'hFFFF, "R7 overflow discarded", pend_count, 16'hFFFF);
    chk(!irq, "R8 masked", irq, 0);
    @(negedge clk); mask_wr = 1; mask_val = 1;
    @(negedge clk); mask_wr = 0;
    #2;
    chk(irq, "R8 unmasked", irq, 1);
    repeat (3) @(negedge clk);
    chk(err_flag, "R7 sticky", err_flag, 1);
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
    #2;
    chk(!err_flag && !irq, "R7 cleared", {err_flag, irq}, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule